// File: doc/BRIEF.md
# Interruptible Cache Maintenance Sequencer

This block takes cache maintenance commands in coprocessor form and carries them out against an external tag store. Each command has a primary register field, a secondary register field, a 3-bit opcode and a data word. The supported commands are:

- invalidate one line of the instruction cache;
- invalidate one line of the data cache;
- clean one line of the data cache;
- clean the whole data cache;
- read a sticky dirty-status flag.

A single-line command names its line in one of two ways. The first is a virtual address, which is looked up against the tags of one set. The second is a set/way word, which names the line directly. The block reads a whole set through its line port. It updates one line at a time with a write strobe. It reports each writeback only as a request/acknowledge handshake.

A whole-cache clean walks every line. It hands each dirty valid line to writeback and then clears that line's dirty bit. An interrupt can stop the walk at any point. When that happens the block reports a restart address equal to the command address plus 4, so a normal interrupt return issues the clean again. The sticky status flag clears when a whole clean is accepted. Any data-cache write seen on the snoop input sets it again. Software can therefore rerun the clean until the flag reads zero.

Top module: `cmc_ctrl`

## Requirements
- R1: A command is acted on only when the primary field is 7. Only these pairs of secondary field and opcode are supported: secondary 5 or 6 or 10 with opcode 1 or 2, and secondary 10 with opcode 0 or 6. Any other command leaves busy low, gives no done pulse, no line write and no writeback.
- R2: Opcode 1 addresses a line by virtual address. The set is data bits [OFF_W +: SET_W] and the tag is data bits [ADDR_W-1 -: TAG_W], compared with the valid ways of that set. On a miss, busy stays high for one cycle, then done pulses with no line write.
- R3: Opcode 2 addresses a line by set/way. The set is data bits [OFF_W +: SET_W] and the way is data bits [ADDR_W-1 -: WAY_W]. The command acts on exactly that line.
- R4: Secondary 5 invalidates a line in the instruction cache (ln_side = 1). Secondary 6 invalidates a line in the data cache (ln_side = 0). An invalidate writes valid 0 and dirty 0, raises no writeback, and takes one busy cycle.
- R5: Secondary 10 with opcode 1 or 2 cleans a line. On a valid dirty line, wb_req stays high until wb_ack is seen. In that same cycle the line is written with valid kept and dirty 0. A clean line gives no writeback.
- R6: Secondary 10 with opcode 0 cleans the whole data cache. It visits lines in ascending index {set, way}, with way as the low bits. It writes back every valid dirty line and pulses done after the last line.
- R7: irq sampled high during a whole clean stops it. In the next cycle busy is low, done does not pulse, and restart_valid pulses with restart_addr equal to cmd_pc plus 4. Lines already cleaned stay clean. A reissued clean walks again from line 0.
- R8: Secondary 10 with opcode 6 pulses rd_valid and done in the cycle after acceptance, with busy never high. rd_data bit 0 is the sticky flag and all other bits are 0.
- R9: The sticky flag is 0 after reset. It clears when a whole clean is accepted. It is set by snp_wr, including during a clean and in the acceptance cycle itself; a set wins over a clear.
- R10: busy is high while a line or walk command runs. A command presented while busy is dropped and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_crn | input | 4 | Primary register field |
| cmd_crm | input | 4 | Secondary register field |
| cmd_op | input | 3 | Opcode field |
| cmd_data | input | ADDR_W | Virtual address or set/way word |
| cmd_pc | input | ADDR_W | Address of the issuing command |
| irq | input | 1 | Interrupt, stops a whole clean |
| snp_wr | input | 1 | A write to the data cache happened |
| busy | output | 1 | Command running |
| done | output | 1 | One-cycle completion pulse |
| rd_valid | output | 1 | Status read data valid |
| rd_data | output | ADDR_W | Status read data |
| restart_valid | output | 1 | One-cycle pulse when a whole clean is stopped |
| restart_addr | output | ADDR_W | Address at which to resume |
| ln_side | output | 1 | 1 selects instruction cache, 0 data cache |
| ln_set | output | SET_W | Set being read or written |
| ln_way | output | WAY_W | Way being written or written back |
| ln_tag | input | WAYS*TAG_W | Tags of every way of ln_set |
| ln_valid | input | WAYS | Valid bits of ln_set |
| ln_dirty | input | WAYS | Dirty bits of ln_set |
| ln_wr | output | 1 | Write strobe for line ln_set/ln_way |
| ln_wr_valid | output | 1 | Valid bit to write |
| ln_wr_dirty | output | 1 | Dirty bit to write |
| wb_req | output | 1 | Writeback request for line ln_set/ln_way |
| wb_ack | input | 1 | Writeback acknowledge |

## Verification
The bench uses the default parameters: four sets, two ways, 32-byte lines and 32-bit addresses. At this size a walk covers all eight lines in a few dozen cycles. That makes it practical to stop a walk after exactly two writebacks and check which lines were left dirty. It also makes it practical to drop a snoop write into the middle of a walk.

With two ways, tag compare and way selection are exercised on both ways of a set. The set/way word's top bit also becomes a real way select.

// File: rtl/cmc_pkg.sv
package cmc_pkg;

    localparam logic [3:0] CRN_CACHE = 4'd7;
    localparam logic [3:0] CRM_IINV  = 4'd5;
    localparam logic [3:0] CRM_DINV  = 4'd6;
    localparam logic [3:0] CRM_DCLN  = 4'd10;

    localparam logic [2:0] OPC_ALL   = 3'd0;
    localparam logic [2:0] OPC_VA    = 3'd1;
    localparam logic [2:0] OPC_SW    = 3'd2;
    localparam logic [2:0] OPC_STAT  = 3'd6;

    typedef enum logic [2:0] {
        K_NONE,
        K_INV,
        K_CLEAN,
        K_ALL,
        K_STAT
    } cmc_kind_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_LOOK,
        S_WALK,
        S_WB
    } cmc_state_e;

endpackage

// File: rtl/cmc_decode.sv
module cmc_decode
    import cmc_pkg::*;
(
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] op,
    output cmc_kind_e  kind,
    output logic       side,
    output logic       by_va
);

    logic line_op;

    always_comb begin
        line_op = (op == OPC_VA) || (op == OPC_SW);
        kind    = K_NONE;
        side    = 1'b0;
        by_va   = (op == OPC_VA);
        if (crn == CRN_CACHE) begin
            unique case (crm)
                CRM_IINV: begin
                    if (line_op) begin
                        kind = K_INV;
                        side = 1'b1;
                    end
                end
                CRM_DINV: begin
                    if (line_op) kind = K_INV;
                end
                CRM_DCLN: begin
                    if (line_op)              kind = K_CLEAN;
                    else if (op == OPC_ALL)   kind = K_ALL;
                    else if (op == OPC_STAT)  kind = K_STAT;
                end
                default: kind = K_NONE;
            endcase
        end
    end

endmodule

// File: rtl/cmc_lookup.sv
module cmc_lookup #(
    parameter int WAY_W = 1,
    parameter int TAG_W = 25
) (
    input  logic [(1<<WAY_W)*TAG_W-1:0] tags,
    input  logic [(1<<WAY_W)-1:0]       valids,
    input  logic [TAG_W-1:0]            tag,
    input  logic                        use_va,
    input  logic [WAY_W-1:0]            way_sel,
    output logic                        hit,
    output logic [WAY_W-1:0]            way
);

    localparam int WAYS = 1 << WAY_W;

    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = valids[w] && (tags[w*TAG_W +: TAG_W] == tag);
    end

    always_comb begin
        hit = 1'b0;
        way = way_sel;
        if (!use_va) begin
            hit = 1'b1;
        end else begin
            for (int w = WAYS - 1; w >= 0; w--) begin
                if (match[w]) begin
                    hit = 1'b1;
                    way = WAY_W'(w);
                end
            end
        end
    end

endmodule

// File: rtl/cmc_status.sv
module cmc_status (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic set,
    output logic flag
);

    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr) flag_d = 1'b0;
        if (set) flag_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;

    p_sticky_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);

    p_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !flag);

endmodule

// File: rtl/cmc_ctrl.sv
module cmc_ctrl
    import cmc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SET_W  = 2,
    parameter int WAY_W  = 1,
    parameter int OFF_W  = 5,
    localparam int WAYS  = 1 << WAY_W,
    localparam int TAG_W = ADDR_W - SET_W - OFF_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    input  logic [3:0]            cmd_crn,
    input  logic [3:0]            cmd_crm,
    input  logic [2:0]            cmd_op,
    input  logic [ADDR_W-1:0]     cmd_data,
    input  logic [ADDR_W-1:0]     cmd_pc,
    input  logic                  irq,
    input  logic                  snp_wr,
    output logic                  busy,
    output logic                  done,
    output logic                  rd_valid,
    output logic [ADDR_W-1:0]     rd_data,
    output logic                  restart_valid,
    output logic [ADDR_W-1:0]     restart_addr,
    output logic                  ln_side,
    output logic [SET_W-1:0]      ln_set,
    output logic [WAY_W-1:0]      ln_way,
    input  logic [WAYS*TAG_W-1:0] ln_tag,
    input  logic [WAYS-1:0]       ln_valid,
    input  logic [WAYS-1:0]       ln_dirty,
    output logic                  ln_wr,
    output logic                  ln_wr_valid,
    output logic                  ln_wr_dirty,
    output logic                  wb_req,
    input  logic                  wb_ack
);

    localparam int IDX_W = SET_W + WAY_W;

    typedef struct packed {
        cmc_state_e          st;
        cmc_kind_e           kind;
        logic                side;
        logic                by_va;
        logic [SET_W-1:0]    set;
        logic [WAY_W-1:0]    way;
        logic [TAG_W-1:0]    tag;
        logic [ADDR_W-1:0]   pc;
        logic                done;
        logic                rdv;
        logic                rdbit;
        logic                rsv;
        logic [ADDR_W-1:0]   rsa;
    } regs_t;

    regs_t r_d, r_q;

    cmc_kind_e        dec_kind;
    logic             dec_side;
    logic             dec_by_va;
    logic             lk_hit;
    logic [WAY_W-1:0] lk_way;
    logic             stat_flag;
    logic             stat_clr;
    logic [IDX_W-1:0] idx_next;
    logic             idx_last;
    logic             abort;

    cmc_decode i_decode (
        .crn   (cmd_crn),
        .crm   (cmd_crm),
        .op    (cmd_op),
        .kind  (dec_kind),
        .side  (dec_side),
        .by_va (dec_by_va)
    );

    cmc_lookup #(
        .WAY_W (WAY_W),
        .TAG_W (TAG_W)
    ) i_lookup (
        .tags    (ln_tag),
        .valids  (ln_valid),
        .tag     (r_q.tag),
        .use_va  (r_q.by_va),
        .way_sel (r_q.way),
        .hit     (lk_hit),
        .way     (lk_way)
    );

    cmc_status i_status (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (stat_clr),
        .set   (snp_wr),
        .flag  (stat_flag)
    );

    assign idx_next = {r_q.set, r_q.way} + IDX_W'(1);
    assign idx_last = &{r_q.set, r_q.way};
    assign abort    = (r_q.kind == K_ALL) && irq;

    always_comb begin
        r_d          = r_q;
        r_d.done     = 1'b0;
        r_d.rdv      = 1'b0;
        r_d.rsv      = 1'b0;
        stat_clr     = 1'b0;
        ln_way       = r_q.way;
        ln_wr        = 1'b0;
        ln_wr_valid  = ln_valid[r_q.way];
        ln_wr_dirty  = ln_dirty[r_q.way];
        wb_req       = 1'b0;

        unique case (r_q.st)
            S_IDLE: begin
                if (cmd_valid) begin
                    unique case (dec_kind)
                        K_STAT: begin
                            r_d.rdv   = 1'b1;
                            r_d.done  = 1'b1;
                            r_d.rdbit = stat_flag;
                        end
                        K_INV, K_CLEAN: begin
                            r_d.st    = S_LOOK;
                            r_d.kind  = dec_kind;
                            r_d.side  = dec_side;
                            r_d.by_va = dec_by_va;
                            r_d.set   = cmd_data[OFF_W +: SET_W];
                            r_d.way   = cmd_data[ADDR_W-1 -: WAY_W];
                            r_d.tag   = cmd_data[ADDR_W-1 -: TAG_W];
                            r_d.pc    = cmd_pc;
                        end
                        K_ALL: begin
                            r_d.st    = S_WALK;
                            r_d.kind  = K_ALL;
                            r_d.side  = 1'b0;
                            r_d.by_va = 1'b0;
                            r_d.set   = '0;
                            r_d.way   = '0;
                            r_d.pc    = cmd_pc;
                            stat_clr  = 1'b1;
                        end
                        default: r_d = r_d;
                    endcase
                end
            end

            S_LOOK: begin
                ln_way      = lk_way;
                ln_wr_valid = ln_valid[lk_way];
                ln_wr_dirty = ln_dirty[lk_way];
                if (!lk_hit) begin
                    r_d.st   = S_IDLE;
                    r_d.done = 1'b1;
                end else if (r_q.kind == K_INV) begin
                    ln_wr       = 1'b1;
                    ln_wr_valid = 1'b0;
                    ln_wr_dirty = 1'b0;
                    r_d.st      = S_IDLE;
                    r_d.done    = 1'b1;
                end else if (ln_valid[lk_way] && ln_dirty[lk_way]) begin
                    r_d.way = lk_way;
                    r_d.st  = S_WB;
                end else begin
                    r_d.st   = S_IDLE;
                    r_d.done = 1'b1;
                end
            end

            S_WALK: begin
                if (abort) begin
                    r_d.st  = S_IDLE;
                    r_d.rsv = 1'b1;
                    r_d.rsa = r_q.pc + ADDR_W'(4);
                end else if (ln_valid[r_q.way] && ln_dirty[r_q.way]) begin
                    r_d.st = S_WB;
                end else if (idx_last) begin
                    r_d.st   = S_IDLE;
                    r_d.done = 1'b1;
                end else begin
                    {r_d.set, r_d.way} = idx_next;
                end
            end

            S_WB: begin
                wb_req = 1'b1;
                if (abort) begin
                    r_d.st  = S_IDLE;
                    r_d.rsv = 1'b1;
                    r_d.rsa = r_q.pc + ADDR_W'(4);
                end else if (wb_ack) begin
                    ln_wr       = 1'b1;
                    ln_wr_dirty = 1'b0;
                    if (r_q.kind == K_ALL && !idx_last) begin
                        {r_d.set, r_d.way} = idx_next;
                        r_d.st = S_WALK;
                    end else begin
                        r_d.st   = S_IDLE;
                        r_d.done = 1'b1;
                    end
                end
            end

            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= S_IDLE;
            r_q.kind  <= K_NONE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy          = (r_q.st != S_IDLE);
    assign done          = r_q.done;
    assign rd_valid      = r_q.rdv;
    assign rd_data       = {{(ADDR_W-1){1'b0}}, r_q.rdbit};
    assign restart_valid = r_q.rsv;
    assign restart_addr  = r_q.rsa;
    assign ln_side       = r_q.side;
    assign ln_set        = r_q.set;

    p_wb_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_ack && !irq) |=> wb_req);

    p_write_only_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ln_wr |-> busy);

    p_abort_no_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        restart_valid |-> (!done && !busy));

    p_read_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !busy);

    p_wb_side_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> !ln_side);

endmodule

// File: tb/test_cmc_ctrl.sv
module test_cmc_ctrl;

    localparam int ADDR_W = 32;
    localparam int SET_W  = 2;
    localparam int WAY_W  = 1;
    localparam int OFF_W  = 5;
    localparam int WAYS   = 2;
    localparam int SETS   = 4;
    localparam int TAG_W  = ADDR_W - SET_W - OFF_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic              cmd_valid = 1'b0;
    logic [3:0]        cmd_crn = '0, cmd_crm = '0;
    logic [2:0]        cmd_op = '0;
    logic [31:0]       cmd_data = '0, cmd_pc = '0;
    logic              irq = 1'b0, snp_wr = 1'b0;
    logic              busy, done, rd_valid, restart_valid;
    logic [31:0]       rd_data, restart_addr;
    logic              ln_side, ln_wr, ln_wr_valid, ln_wr_dirty, wb_req;
    logic [SET_W-1:0]  ln_set;
    logic [WAY_W-1:0]  ln_way;
    logic [WAYS*TAG_W-1:0] ln_tag;
    logic [WAYS-1:0]   ln_valid, ln_dirty;
    logic              wb_ack = 1'b0;

    logic [TAG_W-1:0] tg [2][SETS][WAYS];
    logic             vb [2][SETS][WAYS];
    logic             db [2][SETS][WAYS];

    int checks = 0;
    int errors = 0;
    int wb_cnt = 0;
    int ord_err = 0;
    int prev_idx = -1;
    int first_idx = -1;

    cmc_ctrl i_cmc_ctrl (
        .clk, .rst_n, .cmd_valid, .cmd_crn, .cmd_crm, .cmd_op, .cmd_data,
        .cmd_pc, .irq, .snp_wr, .busy, .done, .rd_valid, .rd_data,
        .restart_valid, .restart_addr, .ln_side, .ln_set, .ln_way, .ln_tag,
        .ln_valid, .ln_dirty, .ln_wr, .ln_wr_valid, .ln_wr_dirty, .wb_req,
        .wb_ack
    );

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            ln_tag[w*TAG_W +: TAG_W] = tg[ln_side][ln_set][w];
            ln_valid[w] = vb[ln_side][ln_set][w];
            ln_dirty[w] = db[ln_side][ln_set][w];
        end
    end

    always @(posedge clk) begin
        wb_ack <= wb_req && !wb_ack;
        if (ln_wr) begin
            vb[ln_side][ln_set][ln_way] <= ln_wr_valid;
            db[ln_side][ln_set][ln_way] <= ln_wr_dirty;
        end
        if (wb_req && wb_ack) begin
            wb_cnt <= wb_cnt + 1;
            if (first_idx < 0) first_idx <= int'({ln_set, ln_way});
            if (int'({ln_set, ln_way}) <= prev_idx) ord_err <= ord_err + 1;
            prev_idx <= int'({ln_set, ln_way});
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_line(int s, int st, int w, int t, bit v, bit d);
        tg[s][st][w] = TAG_W'(t);
        vb[s][st][w] = v;
        db[s][st][w] = d;
    endtask

    task automatic preload();
        for (int s = 0; s < 2; s++)
            for (int st = 0; st < SETS; st++)
                for (int w = 0; w < WAYS; w++)
                    set_line(s, st, w, 0, 1'b0, 1'b0);
        set_line(0, 0, 0, 'h10, 1, 1); set_line(0, 0, 1, 'h11, 1, 0);
        set_line(0, 1, 0, 'h20, 1, 1); set_line(0, 1, 1, 'h21, 1, 1);
        set_line(0, 2, 1, 'h31, 1, 1);
        set_line(0, 3, 0, 'h40, 1, 0); set_line(0, 3, 1, 'h41, 1, 1);
        set_line(1, 0, 0, 'h10, 1, 0); set_line(1, 1, 1, 'h21, 1, 0);
    endtask

    logic last_done, last_rdv, last_rsv;
    logic [31:0] last_rd, last_rsa;

    task automatic start_cmd(logic [3:0] crn, logic [3:0] crm, logic [2:0] op,
                             logic [31:0] data, logic [31:0] pc);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_crn = crn; cmd_crm = crm; cmd_op = op;
        cmd_data = data; cmd_pc = pc;
        prev_idx = -1; first_idx = -1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic finish_cmd(output int nbusy);
        nbusy = 0;
        while (busy && nbusy < 1000) begin
            nbusy++;
            @(negedge clk);
        end
        last_done = done; last_rdv = rd_valid; last_rd = rd_data;
        last_rsv = restart_valid; last_rsa = restart_addr;
    endtask

    task automatic run(logic [3:0] crn, logic [3:0] crm, logic [2:0] op,
                       logic [31:0] data, output int nbusy, output int nwb);
        int w0;
        w0 = wb_cnt;
        start_cmd(crn, crm, op, data, 32'h100);
        finish_cmd(nbusy);
        nwb = wb_cnt - w0;
    endtask

    typedef struct packed {
        logic [3:0]  crn;
        logic [3:0]  crm;
        logic [2:0]  op;
        logic [31:0] data;
        logic        e_done;
        logic [3:0]  e_wb;
        logic [3:0]  e_busy;
        logic        side;
        logic [1:0]  set;
        logic        way;
        logic        e_v;
        logic        e_d;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{4'd7, 4'd10, 3'd1, 32'h0000_0804, 1'b1, 4'd1, 4'd3, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0},
        '{4'd7, 4'd10, 3'd1, 32'h0000_0804, 1'b1, 4'd0, 4'd1, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0},
        '{4'd7, 4'd10, 3'd1, 32'h0000_3BA4, 1'b1, 4'd0, 4'd1, 1'b0, 2'd1, 1'b0, 1'b1, 1'b1},
        '{4'd7, 4'd6,  3'd1, 32'h0000_1024, 1'b1, 4'd0, 4'd1, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0},
        '{4'd7, 4'd10, 3'd2, 32'h8000_0020, 1'b1, 4'd1, 4'd3, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0},
        '{4'd7, 4'd6,  3'd2, 32'h0000_0060, 1'b1, 4'd0, 4'd1, 1'b0, 2'd3, 1'b0, 1'b0, 1'b0},
        '{4'd7, 4'd5,  3'd1, 32'h0000_10A4, 1'b1, 4'd0, 4'd1, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0},
        '{4'd7, 4'd5,  3'd2, 32'h0000_0000, 1'b1, 4'd0, 4'd1, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0},
        '{4'd7, 4'd7,  3'd1, 32'h0000_20E4, 1'b0, 4'd0, 4'd0, 1'b0, 2'd3, 1'b1, 1'b1, 1'b1},
        '{4'd7, 4'd10, 3'd3, 32'h0000_20E4, 1'b0, 4'd0, 4'd0, 1'b0, 2'd3, 1'b1, 1'b1, 1'b1},
        '{4'd6, 4'd10, 3'd1, 32'h0000_20E4, 1'b0, 4'd0, 4'd0, 1'b0, 2'd3, 1'b1, 1'b1, 1'b1},
        '{4'd7, 4'd5,  3'd1, 32'h0000_4CC4, 1'b1, 4'd0, 4'd1, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0}
    };

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int nb, nw;
        preload();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        chk("R10 reset busy", busy, 0);
        chk("R7 reset restart_valid", restart_valid, 0);
        run(4'd7, 4'd10, 3'd6, 32'h0, nb, nw);
        chk("R8 read rd_valid", last_rdv, 1);
        chk("R9 reset flag 0", last_rd, 0);
        chk("R8 read never busy", nb, 0);

        for (int i = 0; i < NV; i++) begin
            run(VEC[i].crn, VEC[i].crm, VEC[i].op, VEC[i].data, nb, nw);
            chk($sformatf("R1/R2/R3 vec%0d done", i), last_done, VEC[i].e_done);
            chk($sformatf("R5 vec%0d writebacks", i), nw, VEC[i].e_wb);
            chk($sformatf("R2/R4 vec%0d busy cycles", i), nb, VEC[i].e_busy);
            chk($sformatf("R3/R4 vec%0d valid", i),
                vb[VEC[i].side][VEC[i].set][VEC[i].way], VEC[i].e_v);
            chk($sformatf("R5 vec%0d dirty", i),
                db[VEC[i].side][VEC[i].set][VEC[i].way], VEC[i].e_d);
        end
        chk("R4 data side untouched by I invalidate", vb[0][1][1], 1);

        run(4'd7, 4'd10, 3'd6, 32'h0, nb, nw);
        chk("R9 no snoop flag 0", last_rd, 0);
        @(negedge clk); snp_wr = 1'b1; @(negedge clk); snp_wr = 1'b0;
        run(4'd7, 4'd10, 3'd6, 32'h0, nb, nw);
        chk("R9 snoop sets flag", last_rd, 1);
        chk("R8 upper bits zero", last_rd[31:1], 0);

        for (int st = 0; st < SETS; st++)
            for (int w = 0; w < WAYS; w++)
                set_line(0, st, w, 'h50 + st, 1, 1);
        begin
            int w0;
            w0 = wb_cnt;
            start_cmd(4'd7, 4'd10, 3'd0, 32'h0, 32'h0000_1F00);
            while (wb_cnt - w0 < 2) @(negedge clk);
            irq = 1'b1;
            @(negedge clk);
            irq = 1'b0;
            chk("R7 busy drops on abort", busy, 0);
            chk("R7 no done on abort", done, 0);
            chk("R7 restart pulse", restart_valid, 1);
            chk("R7 restart address", restart_addr, 32'h0000_1F04);
            chk("R7 cleaned line stays clean", db[0][0][1], 0);
            chk("R7 later line still dirty", db[0][1][0], 1);
        end

        run(4'd7, 4'd10, 3'd0, 32'h0, nb, nw);
        chk("R6 reissue done", last_done, 1);
        chk("R6 remaining writebacks", nw, 6);
        chk("R6 ascending order", ord_err, 0);
        chk("R7 walk restarts at first dirty", first_idx, 2);
        chk("R6 last line clean", db[0][3][1], 0);
        chk("R6 valid kept", vb[0][3][1], 1);

        run(4'd7, 4'd10, 3'd6, 32'h0, nb, nw);
        chk("R9 clean start clears flag", last_rd, 0);

        start_cmd(4'd7, 4'd10, 3'd0, 32'h0, 32'h200);
        @(negedge clk); snp_wr = 1'b1; @(negedge clk); snp_wr = 1'b0;
        finish_cmd(nb);
        chk("R6 clean walk done", last_done, 1);
        run(4'd7, 4'd10, 3'd6, 32'h0, nb, nw);
        chk("R9 snoop during clean sets flag", last_rd, 1);

        @(negedge clk);
        cmd_valid = 1'b1; cmd_crn = 4'd7; cmd_crm = 4'd10; cmd_op = 3'd0;
        snp_wr = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; snp_wr = 1'b0;
        cmd_crm = 4'd6; cmd_op = 3'd2; cmd_data = 32'h8000_0000;
        chk("R10 busy during walk", busy, 1);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        finish_cmd(nb);
        chk("R10 refused command had no effect", vb[0][0][1], 1);
        run(4'd7, 4'd10, 3'd6, 32'h0, nb, nw);
        chk("R9 snoop in accept cycle wins", last_rd, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule